// File: doc/BRIEF.md
# Set-Associative Data Address Translator

This block maps a 32-bit data address issued by a load/store unit onto a physical address. It uses a small set-associative table that software fills. Each table slot holds two words. The tag word carries the virtual page number, a valid flag and a small age counter. The mapping word carries the physical page number, a cache-bypass flag and four access-permission flags, one for each pairing of user or supervisor with read or write.

A lookup presents an address, a write flag, a privilege flag and a translation-enable flag. After a fixed, parameter-chosen number of cycles the block answers once with the physical address, the cache-bypass flag and at most one of three outcomes: hit, miss or permission fault. When translation is off, the address passes through unchanged and the cache-bypass flag follows the top address bit.

A separate programming port writes or reads any tag or mapping word, selected by way and set. Refill after a miss, page-table walking and exception dispatch belong to the surrounding core.

Top module: `dtlb_xlate`

## Requirements
- R1: After reset every slot reads back as zero (invalid, age 0), `req_ready` is 1 and `rsp_valid` is 0.
- R2: With `mmu_en` low (or parameter `MMU_PRESENT` = 0), the response carries `rsp_paddr` = the request address and `rsp_ci` = bit 31 of the address. Hit, miss and fault all stay low and no slot changes.
- R3: The set is address bits [PAGE_BITS +: SET_BITS] and the page tag is bits [31 : PAGE_BITS+SET_BITS]. A way matches only when its valid flag is 1 and its stored tag equals the page tag.
- R4: When more than one way of the set matches, the highest-numbered matching way supplies the result.
- R5: On a match, a supervisor write needs mapping bit 4 and a supervisor read needs bit 3. A user write needs bit 2 and a user read needs bit 1. A missing permission gives `rsp_fault` instead of `rsp_hit`.
- R6: On a match (hit or fault), every way of that set with a nonzero age counts down by one, and the matched way's age is set to USTATES-1.
- R7: On a hit, `rsp_paddr` = {stored physical page, address bits [PAGE_BITS-1:0]} and `rsp_ci` = mapping bit 0. A fault returns the same address and flag.
- R8: With no match, `rsp_miss` is 1, `rsp_paddr` and `rsp_ci` are 0, and no slot changes.
- R9: A request is taken at a rising edge when `req_valid` and `req_ready` are both 1. `rsp_valid` is high for one cycle, MISS_DELAY cycles later for a miss and HIT_DELAY cycles later otherwise. `req_ready` stays low until then, and requests offered while it is low are dropped.
- R10: A write with `cfg_word`=0 stores the tag word as: tag at [31 : PAGE_BITS+SET_BITS], age at [LRU_W:1], valid at [0]. With `cfg_word`=1 it stores the mapping word as: physical page at [31:PAGE_BITS], permission bits at [4:1], bypass flag at [0]. `cfg_rdata` returns the addressed word packed the same way, with every other bit zero.
- R11: `rsp_hit`, `rsp_miss` and `rsp_fault` are never high together, and each pulses only while `rsp_valid` is high.
- R12: While `cfg_we` is high, `req_ready` is low, so no lookup is taken in a programming cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can take a lookup this cycle |
| req_vaddr | input | 32 | Virtual data address |
| req_write | input | 1 | Access is a store |
| req_super | input | 1 | Access made in supervisor mode |
| mmu_en | input | 1 | Translation enabled |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_paddr | output | 32 | Physical address |
| rsp_ci | output | 1 | Access must bypass the data cache |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No matching slot |
| rsp_fault | output | 1 | Matching slot denies the access |
| cfg_we | input | 1 | Programming write strobe |
| cfg_word | input | 1 | 0 selects tag word, 1 selects mapping word |
| cfg_way | input | WAY_W (1) | Way selected for programming |
| cfg_set | input | SET_BITS (6) | Set selected for programming |
| cfg_wdata | input | 32 | Word to write |
| cfg_rdata | output | 32 | Addressed word, packed |

## Verification
The bench builds the block with 4 sets, 2 ways, 4 age states, a hit delay of 1 and a miss delay of 3. With so few sets, random addresses drawn from a small pool of page tags land again and again in the same set. Duplicate tags in both ways, ages that wear down to zero, and refreshes of an already-full counter then come up often. Because the two delays differ, the response timing alone tells a hit or fault from a miss. Reading the tag word back after each lookup shows the age update, or its absence, at the ports.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

    // Fixed bit positions inside the programming words
    localparam int TAG_VALID_BIT = 0;
    localparam int TAG_AGE_LSB   = 1;
    localparam int MAP_CI_BIT    = 0;
    localparam int MAP_PERM_LSB  = 1;

    // Mapping word bits [4:1]: swe sre uwe ure (MSB first)
    typedef struct packed {
        logic swe;
        logic sre;
        logic uwe;
        logic ure;
    } perm_t;

    typedef enum logic [1:0] {
        RK_PASS  = 2'd0,
        RK_HIT   = 2'd1,
        RK_MISS  = 2'd2,
        RK_FAULT = 2'd3
    } rkind_t;

    function automatic logic access_ok(perm_t p, logic wr, logic sup);
        if (sup) return wr ? p.swe : p.sre;
        return wr ? p.uwe : p.ure;
    endfunction

endpackage

// File: rtl/dtlb_store.sv
module dtlb_store
    import dtlb_pkg::*;
#(
    parameter int PAGE_BITS = 13,
    parameter int SET_BITS  = 6,
    parameter int WAYS      = 2,
    parameter int LRU_W     = 2,
    localparam int SETS     = 1 << SET_BITS,
    localparam int VPN_W    = 32 - PAGE_BITS - SET_BITS,
    localparam int PPN_W    = 32 - PAGE_BITS,
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic                cfg_word,
    input  logic [WAY_W-1:0]    cfg_way,
    input  logic [SET_BITS-1:0] cfg_set,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    input  logic [SET_BITS-1:0] lk_set,
    input  logic                age_we,
    input  logic [LRU_W-1:0]    age_next [WAYS],
    output logic [VPN_W-1:0]    rd_vpn   [WAYS],
    output logic                rd_valid [WAYS],
    output logic [LRU_W-1:0]    rd_age   [WAYS],
    output logic [PPN_W-1:0]    rd_ppn   [WAYS],
    output logic                rd_ci    [WAYS],
    output perm_t               rd_perm  [WAYS]
);
    logic [VPN_W-1:0] vpn_q   [WAYS][SETS];
    logic             valid_q [WAYS][SETS];
    logic [LRU_W-1:0] age_q   [WAYS][SETS];
    logic [PPN_W-1:0] ppn_q   [WAYS][SETS];
    logic             ci_q    [WAYS][SETS];
    perm_t            perm_q  [WAYS][SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WAYS; w++) begin
                for (int s = 0; s < SETS; s++) begin
                    vpn_q[w][s]   <= '0;
                    valid_q[w][s] <= 1'b0;
                    age_q[w][s]   <= '0;
                    ppn_q[w][s]   <= '0;
                    ci_q[w][s]    <= 1'b0;
                    perm_q[w][s]  <= '0;
                end
            end
        end else begin
            if (age_we) begin
                for (int w = 0; w < WAYS; w++) age_q[w][lk_set] <= age_next[w];
            end
            if (cfg_we) begin
                if (!cfg_word) begin
                    vpn_q[cfg_way][cfg_set]   <= cfg_wdata[31 -: VPN_W];
                    age_q[cfg_way][cfg_set]   <= cfg_wdata[TAG_AGE_LSB +: LRU_W];
                    valid_q[cfg_way][cfg_set] <= cfg_wdata[TAG_VALID_BIT];
                end else begin
                    ppn_q[cfg_way][cfg_set]  <= cfg_wdata[31 -: PPN_W];
                    perm_q[cfg_way][cfg_set] <= perm_t'(cfg_wdata[MAP_PERM_LSB +: 4]);
                    ci_q[cfg_way][cfg_set]   <= cfg_wdata[MAP_CI_BIT];
                end
            end
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata;

    always_comb begin
        cfg_rdata = '0;
        if (!cfg_word) begin
            cfg_rdata[31 -: VPN_W]              = vpn_q[cfg_way][cfg_set];
            cfg_rdata[TAG_AGE_LSB +: LRU_W]     = age_q[cfg_way][cfg_set];
            cfg_rdata[TAG_VALID_BIT]            = valid_q[cfg_way][cfg_set];
        end else begin
            cfg_rdata[31 -: PPN_W]              = ppn_q[cfg_way][cfg_set];
            cfg_rdata[MAP_PERM_LSB +: 4]        = perm_q[cfg_way][cfg_set];
            cfg_rdata[MAP_CI_BIT]               = ci_q[cfg_way][cfg_set];
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_vpn[w]   = vpn_q[w][lk_set];
        assign rd_valid[w] = valid_q[w][lk_set];
        assign rd_age[w]   = age_q[w][lk_set];
        assign rd_ppn[w]   = ppn_q[w][lk_set];
        assign rd_ci[w]    = ci_q[w][lk_set];
        assign rd_perm[w]  = perm_q[w][lk_set];
    end

    // R10: a programming write never collides with an age update
    a_r10_no_collide: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && age_we));

endmodule

// File: rtl/dtlb_match.sv
module dtlb_match
    import dtlb_pkg::*;
#(
    parameter int PAGE_BITS = 13,
    parameter int SET_BITS  = 6,
    parameter int WAYS      = 2,
    parameter int USTATES   = 4,
    parameter int LRU_W     = 2,
    localparam int VPN_W    = 32 - PAGE_BITS - SET_BITS,
    localparam int PPN_W    = 32 - PAGE_BITS,
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam logic [LRU_W-1:0] AGE_TOP = LRU_W'(USTATES - 1)
) (
    input  logic [VPN_W-1:0]     lk_vpn,
    input  logic [PAGE_BITS-1:0] lk_off,
    input  logic                 lk_write,
    input  logic                 lk_super,
    input  logic [VPN_W-1:0]     rd_vpn   [WAYS],
    input  logic                 rd_valid [WAYS],
    input  logic [LRU_W-1:0]     rd_age   [WAYS],
    input  logic [PPN_W-1:0]     rd_ppn   [WAYS],
    input  logic                 rd_ci    [WAYS],
    input  perm_t                rd_perm  [WAYS],
    output logic                 hit,
    output logic                 deny,
    output logic [31:0]          paddr,
    output logic                 ci,
    output logic [LRU_W-1:0]     age_next [WAYS]
);
    logic [WAY_W-1:0] hway;

    always_comb begin
        hit  = 1'b0;
        hway = '0;
        // ascending scan: the last (highest) matching way wins
        for (int w = 0; w < WAYS; w++) begin
            if (rd_valid[w] && rd_vpn[w] == lk_vpn) begin
                hit  = 1'b1;
                hway = WAY_W'(w);
            end
        end
        deny  = hit && !access_ok(rd_perm[hway], lk_write, lk_super);
        paddr = hit ? {rd_ppn[hway], lk_off} : '0;
        ci    = hit && rd_ci[hway];
        for (int w = 0; w < WAYS; w++) begin
            if (hit && hway == WAY_W'(w))
                age_next[w] = AGE_TOP;
            else if (rd_age[w] != '0)
                age_next[w] = rd_age[w] - LRU_W'(1);
            else
                age_next[w] = '0;
        end
    end

endmodule

// File: rtl/dtlb_resp_timer.sv
module dtlb_resp_timer #(
    parameter int HIT_DELAY  = 1,
    parameter int MISS_DELAY = 2,
    localparam int MAXD      = (HIT_DELAY > MISS_DELAY) ? HIT_DELAY : MISS_DELAY,
    localparam int CW        = $clog2(MAXD + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic slow,
    output logic idle,
    output logic fire
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start)
            cnt_q <= slow ? CW'(MISS_DELAY) : CW'(HIT_DELAY);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign idle = (cnt_q == '0);
    assign fire = (cnt_q == CW'(1));

    // R9: a new lookup is only started when nothing is pending
    a_r9_start_idle: assert property (@(posedge clk) disable iff (rst)
        start |-> idle);

endmodule

// File: rtl/dtlb_xlate.sv
module dtlb_xlate
    import dtlb_pkg::*;
#(
    parameter int PAGE_BITS   = 13,
    parameter int SET_BITS    = 6,
    parameter int WAYS        = 2,
    parameter int USTATES     = 4,
    parameter int HIT_DELAY   = 1,
    parameter int MISS_DELAY  = 2,
    parameter bit MMU_PRESENT = 1'b1,
    localparam int LRU_W      = (USTATES > 1) ? $clog2(USTATES) : 1,
    localparam int VPN_W      = 32 - PAGE_BITS - SET_BITS,
    localparam int PPN_W      = 32 - PAGE_BITS,
    localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [31:0]         req_vaddr,
    input  logic                req_write,
    input  logic                req_super,
    input  logic                mmu_en,
    output logic                rsp_valid,
    output logic [31:0]         rsp_paddr,
    output logic                rsp_ci,
    output logic                rsp_hit,
    output logic                rsp_miss,
    output logic                rsp_fault,
    input  logic                cfg_we,
    input  logic                cfg_word,
    input  logic [WAY_W-1:0]    cfg_way,
    input  logic [SET_BITS-1:0] cfg_set,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata
);
    logic [SET_BITS-1:0] lk_set;
    logic [VPN_W-1:0]    lk_vpn;
    logic                xlate_on, accept, idle, fire;
    logic                m_hit, m_deny, m_ci;
    logic [31:0]         m_paddr;
    logic [LRU_W-1:0]    age_next [WAYS];
    logic [VPN_W-1:0]    rd_vpn   [WAYS];
    logic                rd_valid [WAYS];
    logic [LRU_W-1:0]    rd_age   [WAYS];
    logic [PPN_W-1:0]    rd_ppn   [WAYS];
    logic                rd_ci    [WAYS];
    perm_t               rd_perm  [WAYS];

    rkind_t      kind_q;
    logic [31:0] paddr_q;
    logic        ci_q;

    assign lk_set    = req_vaddr[PAGE_BITS +: SET_BITS];
    assign lk_vpn    = req_vaddr[31 -: VPN_W];
    assign xlate_on  = MMU_PRESENT && mmu_en;
    assign req_ready = idle && !cfg_we;
    assign accept    = req_valid && req_ready;

    dtlb_store #(
        .PAGE_BITS(PAGE_BITS), .SET_BITS(SET_BITS), .WAYS(WAYS), .LRU_W(LRU_W)
    ) u_store (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_word(cfg_word), .cfg_way(cfg_way), .cfg_set(cfg_set),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .lk_set(lk_set), .age_we(accept && xlate_on && m_hit), .age_next(age_next),
        .rd_vpn(rd_vpn), .rd_valid(rd_valid), .rd_age(rd_age),
        .rd_ppn(rd_ppn), .rd_ci(rd_ci), .rd_perm(rd_perm)
    );

    dtlb_match #(
        .PAGE_BITS(PAGE_BITS), .SET_BITS(SET_BITS), .WAYS(WAYS),
        .USTATES(USTATES), .LRU_W(LRU_W)
    ) u_match (
        .lk_vpn(lk_vpn), .lk_off(req_vaddr[PAGE_BITS-1:0]),
        .lk_write(req_write), .lk_super(req_super),
        .rd_vpn(rd_vpn), .rd_valid(rd_valid), .rd_age(rd_age),
        .rd_ppn(rd_ppn), .rd_ci(rd_ci), .rd_perm(rd_perm),
        .hit(m_hit), .deny(m_deny), .paddr(m_paddr), .ci(m_ci),
        .age_next(age_next)
    );

    dtlb_resp_timer #(
        .HIT_DELAY(HIT_DELAY), .MISS_DELAY(MISS_DELAY)
    ) u_timer (
        .clk(clk), .rst(rst), .start(accept), .slow(xlate_on && !m_hit),
        .idle(idle), .fire(fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= RK_PASS;
            paddr_q <= '0;
            ci_q    <= 1'b0;
        end else if (accept) begin
            if (!xlate_on) begin
                kind_q  <= RK_PASS;
                paddr_q <= req_vaddr;
                ci_q    <= req_vaddr[31];
            end else if (!m_hit) begin
                kind_q  <= RK_MISS;
                paddr_q <= '0;
                ci_q    <= 1'b0;
            end else begin
                kind_q  <= m_deny ? RK_FAULT : RK_HIT;
                paddr_q <= m_paddr;
                ci_q    <= m_ci;
            end
        end
    end

    assign rsp_valid = fire;
    assign rsp_paddr = paddr_q;
    assign rsp_ci    = ci_q;
    assign rsp_hit   = fire && kind_q == RK_HIT;
    assign rsp_miss  = fire && kind_q == RK_MISS;
    assign rsp_fault = fire && kind_q == RK_FAULT;

    // R11: outcomes are exclusive and single-cycle
    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_hit, rsp_miss, rsp_fault}));
    a_r11_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    // R8: a miss returns a zero address and no bypass flag
    a_r8_miss_zero: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_paddr == '0 && !rsp_ci));
    // R2: pass-through responses take the bypass flag from address bit 31
    a_r2_pass_ci: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit && !rsp_miss && !rsp_fault) |-> rsp_ci == rsp_paddr[31]);
    // R9: no new request is taken while a response is due
    a_r9_busy: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

endmodule

// File: tb/dtlb_xlate_test.sv
`timescale 1ns/1ps
module dtlb_xlate_test;
    localparam int PB = 13, SB = 2, NW = 2, US = 4, HD = 1, MD = 3;
    localparam int NS = 1 << SB;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_write = 0, req_super = 0, mmu_en = 0;
    logic [31:0] req_vaddr = 0;
    logic req_ready, rsp_valid, rsp_ci, rsp_hit, rsp_miss, rsp_fault;
    logic [31:0] rsp_paddr, cfg_rdata;
    logic cfg_we = 0, cfg_word = 0;
    logic [0:0] cfg_way = 0;
    logic [SB-1:0] cfg_set = 0;
    logic [31:0] cfg_wdata = 0;

    int total = 0, bad = 0;

    bit [16:0] m_vpn [NW][NS];
    bit        m_v   [NW][NS];
    bit [1:0]  m_age [NW][NS];
    bit [18:0] m_ppn [NW][NS];
    bit        m_ci  [NW][NS];
    bit [3:0]  m_perm[NW][NS];   // {swe,sre,uwe,ure} = mapping bits [4:1]

    always #5 clk = ~clk;

    dtlb_xlate #(.PAGE_BITS(PB), .SET_BITS(SB), .WAYS(NW), .USTATES(US),
                 .HIT_DELAY(HD), .MISS_DELAY(MD)) uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] tag_word(int w, int s);
        return {m_vpn[w][s], 12'b0, m_age[w][s], m_v[w][s]};
    endfunction
    function automatic logic [31:0] map_word(int w, int s);
        return {m_ppn[w][s], 8'b0, m_perm[w][s], m_ci[w][s]};
    endfunction
    function automatic bit perm_ok(bit [3:0] p, bit wr, bit sup);
        if (sup) return wr ? p[3] : p[2];
        return wr ? p[1] : p[0];
    endfunction

    task automatic cfg_write(input bit word, input int w, input int s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_word = word; cfg_way = 1'(w); cfg_set = SB'(s); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
        if (!word) begin m_vpn[w][s] = d[31:15]; m_age[w][s] = d[2:1]; m_v[w][s] = d[0]; end
        else begin m_ppn[w][s] = d[31:13]; m_perm[w][s] = d[4:1]; m_ci[w][s] = d[0]; end
    endtask

    task automatic rd_check(input string tag, input bit word, input int w, input int s);
        @(negedge clk);
        cfg_word = word; cfg_way = 1'(w); cfg_set = SB'(s);
        #1;
        chk(tag, cfg_rdata, word ? map_word(w, s) : tag_word(w, s));
    endtask

    task automatic lookup(input string tag, input logic [31:0] va, input bit wr, input bit sup, input bit en);
        int s, hw, n, ed;
        logic [31:0] epa; bit eci; logic [2:0] ek;   // {fault,miss,hit}
        s = int'(va[14:13]); hw = -1;
        if (en) for (int w = 0; w < NW; w++)
            if (m_v[w][s] && m_vpn[w][s] == va[31:15]) hw = w;
        if (!en) begin epa = va; eci = va[31]; ek = 3'b000; ed = HD; end
        else if (hw < 0) begin epa = 0; eci = 0; ek = 3'b010; ed = MD; end
        else begin
            epa = {m_ppn[hw][s], va[12:0]}; eci = m_ci[hw][s];
            ek = perm_ok(m_perm[hw][s], wr, sup) ? 3'b001 : 3'b100; ed = HD;
            for (int w = 0; w < NW; w++)
                if (w == hw) m_age[w][s] = 2'(US - 1);
                else if (m_age[w][s] != 0) m_age[w][s]--;
        end
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_super = sup; mmu_en = en; req_valid = 1;
        chk({tag, " R9 ready"}, 32'(req_ready), 1);
        @(negedge clk);
        req_valid = 0;
        n = 1;
        while (!rsp_valid && n < 20) begin @(negedge clk); n++; end
        chk({tag, " R9 latency"}, n, ed);
        chk({tag, " R11 kind"}, {rsp_fault, rsp_miss, rsp_hit}, ek);
        chk({tag, " R7 paddr"}, rsp_paddr, epa);
        chk({tag, " R7 ci"}, 32'(rsp_ci), 32'(eci));
        @(negedge clk);
        chk({tag, " R11 pulse"}, 32'(rsp_valid), 0);
        for (int w = 0; w < NW; w++) rd_check({tag, " R6 age"}, 0, w, s);
    endtask

    initial begin
        #2ms;
        bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7781));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", 32'(req_ready), 1);
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        for (int s = 0; s < NS; s++) begin
            rd_check("R1 tag word", 0, 1, s);
            rd_check("R1 map word", 1, 0, s);
        end
        // R8 miss on empty table
        lookup("R8 empty", 32'h1234_5678, 0, 1, 1);
        // R2 pass-through, both halves of the address space
        lookup("R2 high", 32'h8000_1234, 1, 0, 0);
        lookup("R2 low", 32'h7FFF_FFFF, 0, 0, 0);
        // R10 programming and R7 hit: tag 0x00042, set 1
        cfg_write(0, 0, 1, {17'h00042, 12'hABC, 2'b00, 1'b1});
        cfg_write(1, 0, 1, {19'h12345, 8'hFF, 4'b1111, 1'b1});
        rd_check("R10 tag pack", 0, 0, 1);
        rd_check("R10 map pack", 1, 0, 1);
        lookup("R7 hit", {17'h00042, 2'd1, 13'h0ABC}, 0, 0, 1);
        // R4 duplicate tag in way 1, different page
        cfg_write(0, 1, 1, {17'h00042, 12'h0, 2'b00, 1'b1});
        cfg_write(1, 1, 1, {19'h00777, 8'h0, 4'b0001, 1'b0});
        lookup("R4 high way", {17'h00042, 2'd1, 13'h1FFF}, 0, 0, 1);
        // R5 permissions on way1 (only user read)
        lookup("R5 user write", {17'h00042, 2'd1, 13'h0010}, 1, 0, 1);
        lookup("R5 super read", {17'h00042, 2'd1, 13'h0020}, 0, 1, 1);
        cfg_write(1, 1, 1, {19'h00777, 8'h0, 4'b1000, 1'b0});
        lookup("R5 super write", {17'h00042, 2'd1, 13'h0030}, 1, 1, 1);
        lookup("R5 super read denied", {17'h00042, 2'd1, 13'h0030}, 0, 1, 1);
        // R3 invalid slot with matching tag
        cfg_write(0, 0, 2, {17'h00099, 12'h0, 2'b11, 1'b0});
        lookup("R3 invalid", {17'h00099, 2'd2, 13'h0}, 0, 0, 1);
        // R3 right tag, wrong set
        lookup("R3 other set", {17'h00042, 2'd3, 13'h0}, 0, 0, 1);
        // R9 request while busy is dropped
        @(negedge clk);
        req_vaddr = {17'h00055, 2'd0, 13'h0}; mmu_en = 1; req_valid = 1;
        @(negedge clk);
        req_vaddr = {17'h00042, 2'd1, 13'h0};
        chk("R9 busy ready", 32'(req_ready), 0);
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        chk("R9 miss response", {rsp_fault, rsp_miss, rsp_hit}, 3'b010);
        repeat (4) begin
            @(negedge clk);
            chk("R9 dropped no rsp", 32'(rsp_valid), 0);
        end
        rd_check("R9 dropped no age", 0, 0, 1);
        rd_check("R9 dropped no age", 0, 1, 1);
        // R12 programming blocks lookup
        @(negedge clk);
        cfg_we = 1; cfg_word = 0; cfg_way = 0; cfg_set = 2'd1;
        cfg_wdata = {17'h00042, 12'h0, 2'b01, 1'b1};
        req_vaddr = {17'h00042, 2'd1, 13'h0}; req_valid = 1;
        #1 chk("R12 ready low", 32'(req_ready), 0);
        @(negedge clk);
        cfg_we = 0; req_valid = 0;
        m_vpn[0][1] = 17'h00042; m_age[0][1] = 2'b01; m_v[0][1] = 1;
        repeat (3) begin
            @(negedge clk);
            chk("R12 no rsp", 32'(rsp_valid), 0);
        end
        rd_check("R12 write kept", 0, 0, 1);
        // random mix
        for (int i = 0; i < 400; i++) begin
            bit [16:0] pool [4] = '{17'h00000, 17'h00001, 17'h0ABCD, 17'h1FFFF};
            int w = int'($urandom_range(0, NW - 1));
            int s = int'($urandom_range(0, NS - 1));
            logic [31:0] d = $urandom;
            if ($urandom_range(0, 9) < 3) begin
                if ($urandom_range(0, 1) == 0) cfg_write(0, w, s, {pool[$urandom_range(0, 3)], d[14:0]});
                else cfg_write(1, w, s, d);
            end else begin
                lookup("R3 R5 R6 random", {pool[$urandom_range(0, 3)], 2'(s), d[12:0]},
                       d[13], d[14], $urandom_range(0, 9) != 0);
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule